// File: doc/BRIEF.md
# Cascaded Switch-Bank Serial Loader

This block runs on the host side and programs a chain of cascaded 8-channel switch-control registers. Each register in the chain has an internal shift register, a bank of latches that pass data while their enable input is low, a clear input, and a serial output that feeds the next register. The loader takes an N×8-bit pattern and a start strobe. It then produces serial data, a shift clock, an active-low latch enable and an active-high clear. It signals completion with a one-cycle done pulse.

Every interface timing limit is enforced by counting system clocks. The system clock frequency, the number of chained devices and each nanosecond limit are parameters. The cycle counts are derived from them by rounding up. Serial data changes only on the falling edge of the shift clock, so each bit is already settled a full half period before the rising edge that captures it. Latch enable stays high during the whole shift. After the shift, it is pulsed low once so that every switch takes its new state at the same moment. A clear command raises the clear line for a timed pulse. It opens every switch and empties the chain.

Top module: `swbank_loader`

## Requirements
- R1: During and directly after reset: latch enable is high, the shift clock is low, clear is low, serial data is low, and busy and done are both low.
- R2: The pattern is sent most significant bit first. After a load, device k (k=0 is fed directly by the loader) drives its switches 7..0 from pattern bits 8k+7..8k. A 1 means on. The last device therefore carries the top byte, with the pattern MSB on its switch 7.
- R3: Each high phase and each low phase of the shift clock lasts at least the half-period count. This count is the largest of ceil(f_sys/(2·5 MHz)), the 15 ns setup time and the 35 ns hold time, all converted to cycles. Serial data never changes while the shift clock is high.
- R4: Latch enable stays high whenever the shift clock is high. No switch output changes while latch enable is high and clear is low.
- R5: A load produces exactly 8×N rising edges of the shift clock.
- R6: After the last falling edge of the shift clock, at least ceil(150 ns) of cycles pass before latch enable falls. Latch enable then stays low for at least ceil(150 ns) of cycles and returns high.
- R7: A clear command holds the clear line high for at least ceil(150 ns) of cycles. During that time the shift clock is low, latch enable is high and serial data is low. Afterwards every switch is off and the chain holds zeros.
- R8: Busy is high from the cycle after a request is accepted until the sequence ends. Done is a single-cycle pulse. A start or clear request made while busy is ignored.
- R9: If start and clear are both requested in the same idle cycle, the clear wins and no shift clock edge is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request a load of patternIn (taken only when idle) |
| clearReq | input | 1 | Request a clear pulse (taken only when idle; wins over start) |
| patternIn | input | 8*NUM_DEV | Switch pattern; bits 8k+7..8k go to device k |
| serDataOut | output | 1 | Serial data to the first device in the chain |
| shiftClkOut | output | 1 | Shift clock to all devices |
| latchEnNOut | output | 1 | Active-low latch enable to all devices |
| clearOut | output | 1 | Active-high clear to all devices |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
Run-length counters next to the control logic check every cycle that the minimum widths hold: the shift clock's high and low phases, the wait before the latch strobe, the latch pulse and the clear pulse. Further per-cycle checks cover data stability during the high phase, latch enable staying high while clocking, an idle interface while not busy, and the single-cycle done pulse. Other properties depend on the whole chain and can only be shown by the bench's scenarios. These are the bit order across cascaded devices, the exact edge count, the final switch states, the frozen outputs during shifting, the ignoring of requests made while busy, and clear winning over start. The bench checks them against behavioural models of the chained registers.

// File: rtl/swbank_pkg.sv
`timescale 1ns/1ps
package swbank_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_SETTLE,
    ST_STROBE,
    ST_WIPE,
    ST_DONE
  } loadState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic shift;
    logic wipe;
  } dpCmd_t;

  // nanoseconds to system cycles, rounded up, never below one
  function automatic int nsToCycles(longint sysHz, longint ns);
    longint c;
    c = (sysHz * ns + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swbank_datapath.sv
`timescale 1ns/1ps
module swbank_datapath
  import swbank_pkg::*;
#(
  parameter int TOTAL_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCmd_t                cmd,
  input  logic [TOTAL_BITS-1:0] patternIn,
  output logic                  serDataOut
);

  logic [TOTAL_BITS-1:0] shReg;

  // top bit leaves first; wipe beats load beats shift
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          shReg <= '0;
    else if (cmd.wipe)  shReg <= '0;
    else if (cmd.load)  shReg <= patternIn;
    else if (cmd.shift) shReg <= {shReg[TOTAL_BITS-2:0], 1'b0};
  end

  assign serDataOut = shReg[TOTAL_BITS-1];

  // R9: control never asks for a load and a wipe together
  a_r9_wipe_excludes_load: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wipe |-> !cmd.load);

  // R7: serial line is low in the cycle after a wipe
  a_r7_wipe_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wipe |=> !serDataOut);

endmodule

// File: rtl/swbank_ctrl.sv
`timescale 1ns/1ps
module swbank_ctrl
  import swbank_pkg::*;
#(
  parameter int TOTAL_BITS = 16,
  parameter int HALF_CYC   = 20,
  parameter int SU_CYC     = 30,
  parameter int PW_CYC     = 30,
  parameter int CLR_CYC    = 30
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startReq,
  input  logic   clearReq,
  output dpCmd_t cmd,
  output logic   shiftClkQ,
  output logic   latchEnNQ,
  output logic   clearQ,
  output logic   busy,
  output logic   done
);

  localparam int MAX_CYC = maxOf(maxOf(HALF_CYC, SU_CYC), maxOf(PW_CYC, CLR_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(TOTAL_BITS);

  loadState_t       state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitLeft;
  logic             timeUp;

  assign timeUp = (cnt == '0);

  always_comb begin
    cmd       = '0;
    cmd.wipe  = (state == ST_IDLE) && clearReq;
    cmd.load  = (state == ST_IDLE) && startReq && !clearReq;
    cmd.shift = (state == ST_HIGH) && timeUp && (bitLeft != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      bitLeft   <= '0;
      shiftClkQ <= 1'b0;
      latchEnNQ <= 1'b1;
      clearQ    <= 1'b0;
    end else begin
      if (!timeUp) cnt <= cnt - 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (clearReq) begin
            state  <= ST_WIPE;
            clearQ <= 1'b1;
            cnt    <= CNT_W'(CLR_CYC - 1);
          end else if (startReq) begin
            state   <= ST_LOW;
            cnt     <= CNT_W'(HALF_CYC - 1);
            bitLeft <= BIT_W'(TOTAL_BITS - 1);
          end
        end
        ST_LOW: if (timeUp) begin
          state     <= ST_HIGH;
          shiftClkQ <= 1'b1;
          cnt       <= CNT_W'(HALF_CYC - 1);
        end
        ST_HIGH: if (timeUp) begin
          shiftClkQ <= 1'b0;
          if (bitLeft == '0) begin
            state <= ST_SETTLE;
            cnt   <= CNT_W'(SU_CYC - 1);
          end else begin
            state   <= ST_LOW;
            cnt     <= CNT_W'(HALF_CYC - 1);
            bitLeft <= bitLeft - 1'b1;
          end
        end
        ST_SETTLE: if (timeUp) begin
          state     <= ST_STROBE;
          latchEnNQ <= 1'b0;
          cnt       <= CNT_W'(PW_CYC - 1);
        end
        ST_STROBE: if (timeUp) begin
          state     <= ST_DONE;
          latchEnNQ <= 1'b1;
        end
        ST_WIPE: if (timeUp) begin
          state  <= ST_DONE;
          clearQ <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  // run-length counters for the width properties (saturating)
  logic [15:0] hiRun, loRun, sinceFall, leLowRun, clrRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun <= '0; loRun <= '0; sinceFall <= '0; leLowRun <= '0; clrRun <= '0;
    end else begin
      hiRun     <= shiftClkQ  ? ((&hiRun) ? hiRun : hiRun + 1'b1) : '0;
      loRun     <= !shiftClkQ ? ((&loRun) ? loRun : loRun + 1'b1) : '0;
      sinceFall <= !shiftClkQ ? ((&sinceFall) ? sinceFall : sinceFall + 1'b1) : '0;
      leLowRun  <= !latchEnNQ ? ((&leLowRun) ? leLowRun : leLowRun + 1'b1) : '0;
      clrRun    <= clearQ     ? ((&clrRun) ? clrRun : clrRun + 1'b1) : '0;
    end
  end

  a_r3_high_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftClkQ) |-> hiRun >= 16'(HALF_CYC));
  a_r3_low_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shiftClkQ) |-> loRun >= 16'(HALF_CYC));
  a_r4_latch_high_while_clocking: assert property (@(posedge clk) disable iff (!rstN)
    shiftClkQ |-> latchEnNQ);
  a_r6_strobe_setup: assert property (@(posedge clk) disable iff (!rstN)
    $fell(latchEnNQ) |-> sinceFall >= 16'(SU_CYC));
  a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(latchEnNQ) |-> leLowRun >= 16'(PW_CYC));
  a_r7_clear_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clearQ) |-> clrRun >= 16'(CLR_CYC));
  a_r7_clear_quiet: assert property (@(posedge clk) disable iff (!rstN)
    clearQ |-> (latchEnNQ && !shiftClkQ));
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (latchEnNQ && !shiftClkQ && !clearQ));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/swbank_loader.sv
`timescale 1ns/1ps
module swbank_loader
  import swbank_pkg::*;
#(
  parameter int SYS_CLK_HZ    = 200_000_000,
  parameter int NUM_DEV       = 2,
  parameter int SHIFT_MAX_HZ  = 5_000_000,
  parameter int DATA_SETUP_NS = 15,
  parameter int DATA_HOLD_NS  = 35,
  parameter int LE_SETUP_NS   = 150,
  parameter int LE_WIDTH_NS   = 150,
  parameter int CLR_WIDTH_NS  = 150
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic                 clearReq,
  input  logic [8*NUM_DEV-1:0] patternIn,
  output logic                 serDataOut,
  output logic                 shiftClkOut,
  output logic                 latchEnNOut,
  output logic                 clearOut,
  output logic                 busy,
  output logic                 done
);

  localparam int TOTAL_BITS = 8 * NUM_DEV;
  localparam int RATE_CYC   = int'((longint'(SYS_CLK_HZ) + 2 * longint'(SHIFT_MAX_HZ) - 1)
                                   / (2 * longint'(SHIFT_MAX_HZ)));
  localparam int HALF_CYC   = maxOf(RATE_CYC, maxOf(nsToCycles(SYS_CLK_HZ, DATA_SETUP_NS),
                                                    nsToCycles(SYS_CLK_HZ, DATA_HOLD_NS)));
  localparam int SU_CYC     = nsToCycles(SYS_CLK_HZ, LE_SETUP_NS);
  localparam int PW_CYC     = nsToCycles(SYS_CLK_HZ, LE_WIDTH_NS);
  localparam int CLR_CYC    = nsToCycles(SYS_CLK_HZ, CLR_WIDTH_NS);

  dpCmd_t cmd;

  swbank_ctrl #(
    .TOTAL_BITS(TOTAL_BITS),
    .HALF_CYC  (HALF_CYC),
    .SU_CYC    (SU_CYC),
    .PW_CYC    (PW_CYC),
    .CLR_CYC   (CLR_CYC)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .clearReq (clearReq),
    .cmd      (cmd),
    .shiftClkQ(shiftClkOut),
    .latchEnNQ(latchEnNOut),
    .clearQ   (clearOut),
    .busy     (busy),
    .done     (done)
  );

  swbank_datapath #(
    .TOTAL_BITS(TOTAL_BITS)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .patternIn (patternIn),
    .serDataOut(serDataOut)
  );

  // R3: data from the datapath holds still while the clock from control is high
  a_r3_data_still_high: assert property (@(posedge clk) disable iff (!rstN)
    shiftClkOut |-> $stable(serDataOut));

endmodule

// File: tb/test_swbank_loader.sv
`timescale 1ns/1ps
module chainStageModel (
  input  logic       din,
  input  logic       sck,
  input  logic       leN,
  input  logic       clr,
  output logic       dout,
  output logic [7:0] sw
);
  logic [7:0] sr;
  always @(posedge sck or posedge clr) begin
    if (clr) sr <= 8'h00;
    else     sr <= {sr[6:0], din};
  end
  always_latch begin
    if (clr)       sw <= 8'h00;
    else if (!leN) sw <= sr;
  end
  assign dout = sr[7];
endmodule

module test_swbank_loader;
  localparam int N      = 3;
  localparam int TOTAL  = 8 * N;
  localparam int CLK_NS = 5;
  // bench's own cycle limits from the requirement figures
  localparam int HALF_MIN = ((100 + CLK_NS - 1) / CLK_NS > (35 + CLK_NS - 1) / CLK_NS)
                            ? (100 + CLK_NS - 1) / CLK_NS : (35 + CLK_NS - 1) / CLK_NS;
  localparam int T150 = (150 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, clearReq = 1'b0;
  logic [TOTAL-1:0] patternIn = '0;
  logic serDataOut, shiftClkOut, latchEnNOut, clearOut, busy, done;

  always #2.5 clk = ~clk;

  swbank_loader #(.SYS_CLK_HZ(200_000_000), .NUM_DEV(N)) i_swbank_loader (
    .clk(clk), .rstN(rstN), .startReq(startReq), .clearReq(clearReq),
    .patternIn(patternIn), .serDataOut(serDataOut), .shiftClkOut(shiftClkOut),
    .latchEnNOut(latchEnNOut), .clearOut(clearOut), .busy(busy), .done(done));

  logic [N:0] link;
  logic [TOTAL-1:0] swAll;
  assign link[0] = serDataOut;
  for (genvar k = 0; k < N; k++) begin : g_chain
    chainStageModel i_stage (.din(link[k]), .sck(shiftClkOut), .leN(latchEnNOut),
      .clr(clearOut), .dout(link[k+1]), .sw(swAll[8*k +: 8]));
  end

  int nTests = 0, nFail = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected switch image: push bits MSB first through an abstract 8N chain
  function automatic logic [TOTAL-1:0] expSwitches(input logic [TOTAL-1:0] p);
    logic [TOTAL-1:0] chain = '0;
    for (int i = 0; i < TOTAL; i++) chain = {chain[TOTAL-2:0], p[TOTAL-1-i]};
    return chain;
  endfunction

  // monitor, sampled away from the active edge
  int riseCnt, minHi, minLo, dataChgHigh, swChgLatched, leLowClk, setupAtLe, leWidth;
  int clrWidth, clrPulses, clrBad, doneCnt;
  int hiRun = 0, loRun = 0, sinceFall = 0, leLowRun = 0, clrRun = 0;
  logic pSck = 0, pLe = 1, pClr = 0, pData = 0;
  logic [TOTAL-1:0] pSw = '0;

  always @(negedge clk) if (rstN) begin
    if ((startReq || clearReq) && !busy) begin
      riseCnt = 0; minHi = 1 << 30; minLo = 1 << 30; dataChgHigh = 0; swChgLatched = 0;
      leLowClk = 0; setupAtLe = -1; leWidth = -1; clrWidth = -1; clrPulses = 0;
      clrBad = 0; doneCnt = 0;
    end
    if (shiftClkOut && !pSck) begin riseCnt++; if (loRun < minLo) minLo = loRun; end
    if (!shiftClkOut && pSck && hiRun < minHi) minHi = hiRun;
    if (shiftClkOut && serDataOut != pData) dataChgHigh++;
    if (shiftClkOut && !latchEnNOut) leLowClk++;
    if (!latchEnNOut && pLe) setupAtLe = sinceFall;
    if (latchEnNOut && !pLe) leWidth = leLowRun;
    if (clearOut && !pClr) clrPulses++;
    if (!clearOut && pClr) clrWidth = clrRun;
    if (clearOut && (shiftClkOut || !latchEnNOut || serDataOut)) clrBad++;
    if (swAll != pSw && latchEnNOut && pLe && !clearOut && !pClr) swChgLatched++;
    if (done) doneCnt++;
    hiRun     = shiftClkOut ? hiRun + 1 : 0;
    loRun     = shiftClkOut ? 0 : loRun + 1;
    sinceFall = shiftClkOut ? 0 : sinceFall + 1;
    leLowRun  = !latchEnNOut ? leLowRun + 1 : 0;
    clrRun    = clearOut ? clrRun + 1 : 0;
    pSck = shiftClkOut; pLe = latchEnNOut; pClr = clearOut; pData = serDataOut; pSw = swAll;
  end

  task automatic runOp(input bit doStart, input bit doClear, input logic [TOTAL-1:0] p,
                       input bit interfere, input logic [TOTAL-1:0] other);
    int waited = 0;
    @(posedge clk); #1;
    startReq = doStart; clearReq = doClear; patternIn = p;
    @(posedge clk); #1;
    startReq = 0; clearReq = 0;
    @(negedge clk);
    check(busy === 1'b1, "R8", "busy after accept", busy, 1);
    if (interfere) begin
      repeat (100) @(posedge clk);
      #1; startReq = 1; clearReq = 1; patternIn = other;
      @(posedge clk); #1; startReq = 0; clearReq = 0;
    end
    while (!done && waited < 5000) begin @(negedge clk); waited++; end
    check(waited < 5000, "R8", "sequence finished", waited, 5000);
    repeat (3) @(negedge clk);
    check(!busy, "R8", "busy low after done", busy, 0);
    check(doneCnt == 1, "R8", "done pulse cycles", doneCnt, 1);
  endtask

  task automatic doLoad(input logic [TOTAL-1:0] p);
    runOp(1, 0, p, 0, '0);
    check(swAll == expSwitches(p), "R2", "switch image", swAll, expSwitches(p));
    check(riseCnt == TOTAL, "R5", "rising edges", riseCnt, TOTAL);
    check(minHi >= HALF_MIN && minLo >= HALF_MIN, "R3", "min half period",
          (minHi < minLo) ? minHi : minLo, HALF_MIN);
    check(dataChgHigh == 0, "R3", "data moves while clock high", dataChgHigh, 0);
    check(swChgLatched == 0 && leLowClk == 0, "R4", "outputs frozen while shifting",
          swChgLatched + leLowClk, 0);
    check(setupAtLe >= T150, "R6", "strobe setup cycles", setupAtLe, T150);
    check(leWidth >= T150, "R6", "strobe width cycles", leWidth, T150);
  endtask

  initial begin
    #(190000 * CLK_NS);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    logic [TOTAL-1:0] keep;
    void'($urandom(32'h1A2B3C4D));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(latchEnNOut === 1'b1 && shiftClkOut === 1'b0 && clearOut === 1'b0,
          "R1", "pins in reset", {latchEnNOut, shiftClkOut, clearOut}, 3'b100);
    check(serDataOut === 1'b0 && busy === 1'b0 && done === 1'b0, "R1", "status in reset",
          {serDataOut, busy, done}, 0);
    #1 rstN = 1;
    repeat (3) @(negedge clk);
    check(latchEnNOut === 1'b1 && !shiftClkOut && !clearOut && !busy, "R1", "idle after reset",
          {latchEnNOut, shiftClkOut, clearOut, busy}, 4'b1000);

    // R7: clear from an unknown chain state
    runOp(0, 1, '0, 0, '0);
    check(swAll == '0, "R7", "switches off after clear", swAll, 0);

    // directed corner patterns
    doLoad({TOTAL{1'b1}});
    doLoad('0);
    doLoad({1'b1, {(TOTAL-1){1'b0}}});
    check(swAll[TOTAL-1] == 1'b1 && swAll[TOTAL-2:0] == '0, "R2", "MSB on last switch 7",
          swAll, {1'b1, {(TOTAL-1){1'b0}}});
    doLoad({{(TOTAL-1){1'b0}}, 1'b1});
    doLoad({(TOTAL/2){2'b10}});
    for (int i = 0; i < 20; i++) doLoad(TOTAL'({$urandom, $urandom}));

    // R7: clear after a non-zero load
    doLoad({(TOTAL/2){2'b01}});
    runOp(0, 1, '0, 0, '0);
    check(clrPulses == 1 && clrWidth >= T150, "R7", "clear width", clrWidth, T150);
    check(clrBad == 0, "R7", "quiet lines during clear", clrBad, 0);
    check(swAll == '0 && link[N] == 1'b0, "R7", "chain empty after clear", swAll, 0);

    // R8: requests while busy are ignored
    keep = TOTAL'(24'hC3A55A);
    runOp(1, 0, keep, 1, {TOTAL{1'b1}});
    check(swAll == expSwitches(keep), "R8", "load kept despite mid-run requests", swAll,
          expSwitches(keep));
    check(clrPulses == 0 && riseCnt == TOTAL, "R8", "no extra clear or edges",
          clrPulses * 1000 + riseCnt, TOTAL);

    // R9: simultaneous start and clear -> clear wins
    runOp(1, 1, {TOTAL{1'b1}}, 0, '0);
    check(clrPulses == 1 && riseCnt == 0, "R9", "clear wins over start",
          clrPulses * 1000 + riseCnt, 1000);
    check(swAll == '0, "R9", "switches off", swAll, 0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule